// File: doc/BRIEF.md
# Flag-Setting ALU with Saturation

This block is the 32-bit integer arithmetic and logic stage of a processor datapath. Each cycle it may accept one operation: a code, two register operands and an optional immediate field. One clock edge later it presents the result together with a write strobe. It also keeps a five-bit condition register that later branch and conditional-set logic reads.

The first operand can come from the register input or from a 5-bit or 16-bit immediate field. How the immediate is widened depends on the class of the operation. Arithmetic operations update zero, sign, carry and overflow. The saturating forms also clamp the result to the signed limits and raise a sticky saturation bit, which only the external clear input removes. Logical operations touch fewer flags, and a compare sets flags without writing a result. Multiply, divide, shifts and the register file are separate blocks.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_out` becomes 0, `res_wr` becomes 0 and all five bits of `flags_out` become 0.
- R2: An operation presented with `op_valid` high is applied at the next rising edge. `res_wr` is high for exactly that following cycle when the operation writes. `res_out` keeps its last written value in every cycle without a write.
- R3: Add (code 0) gives `opnd_b + src`. CY is set when the unsigned sum does not fit in 32 bits. OV is set when both inputs have the same sign and the result's sign differs from it.
- R4: Subtract (code 1) gives `opnd_b - src` and reverse subtract (code 2) gives `src - opnd_b`. CY means an unsigned borrow, meaning the subtrahend exceeds the minuend. OV is set when the two signs differ and the result's sign differs from the minuend.
- R5: Compare (code 3) updates Z, S, CY and OV exactly as subtract would. It drives no write strobe and leaves `res_out` unchanged.
- R6: Saturating add (code 4) and saturating subtract (code 5) behave like codes 0 and 1. On overflow, the written result is 0x7FFFFFFF if the exact result is positive and 0x80000000 if it is negative. Z, S, CY and OV still describe the wrapped 32-bit result.
- R7: Flag bit 4 (SAT) is set by any saturating operation that overflows. A high `sat_clr` clears it in any cycle. If a clear and a new saturation happen in the same cycle, the bit ends set. No other event changes it.
- R8: OR (8), AND (9), XOR (10) and NOT (11, result `~src`) set Z and S from the result, clear OV and leave CY unchanged. Flag bit positions are Z=0, S=1, CY=2, OV=3, SAT=4.
- R9: AND with an immediate source (`imm_mode` 1 or 2) always leaves S cleared.
- R10: For `imm_mode` 1, `src` is `imm_val[4:0]`. For `imm_mode` 2, it is `imm_val[15:0]`. The field is sign-extended for codes 0 to 5 and zero-extended for codes 8 to 11. With `imm_mode` 0 or 3, `src` is `opnd_a`.
- R11: Codes 6, 7 and 12 to 15 are ignored: no write strobe, `res_out` unchanged, and no flag change apart from a `sat_clr` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | Register source operand |
| opnd_b | input | 32 | Second register operand (destination value) |
| imm_val | input | 16 | Immediate field |
| imm_mode | input | 2 | 0/3 register source, 1 short immediate, 2 long immediate |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| res_out | output | 32 | Last written result |
| res_wr | output | 1 | Result write strobe |
| flags_out | output | 5 | Condition flags {SAT, OV, CY, S, Z} |

## Verification
Operands at the signed and unsigned limits (0, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) separate carry from overflow. They also separate borrow from sign and positive clamping from negative clamping, and a small-value case cannot tell these apart. Immediate fields with their top bit set show whether sign extension or zero extension was applied to each operation class. A carry set just before a logical operation shows whether that operation keeps CY. Sequences of clears, saturations and both at once show whether SAT is sticky and which one takes priority. Unassigned codes, compares and long random streams with mixed valid and clear then test write gating and flag retention against a behavioural model in every cycle.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_RSUB = 4'd2,
        OP_CMP  = 4'd3,
        OP_SADD = 4'd4,
        OP_SSUB = 4'd5,
        OP_OR   = 4'd8,
        OP_AND  = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG     = 2'd0,
        SRC_SHORT   = 2'd1,
        SRC_LONG    = 2'd2,
        SRC_REG_ALT = 2'd3
    } src_mode_e;

    // Bit 0 is zero, bit 4 the sticky saturation flag.
    typedef struct packed {
        logic sat;
        logic ov;
        logic cy;
        logic s;
        logic z;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

    function automatic logic op_is_arith(alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_RSUB, OP_CMP, OP_SADD, OP_SSUB: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_logic(alu_op_e op);
        case (op)
            OP_OR, OP_AND, OP_XOR, OP_NOT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_sat(alu_op_e op);
        return (op == OP_SADD) || (op == OP_SSUB);
    endfunction

    function automatic logic op_is_sub(alu_op_e op);
        case (op)
            OP_SUB, OP_RSUB, OP_CMP, OP_SSUB: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_writes(alu_op_e op);
        return (op_is_arith(op) && (op != OP_CMP)) || op_is_logic(op);
    endfunction

    // Which flag fields an operation is allowed to replace.
    function automatic alu_flags_t flag_update_mask(alu_op_e op);
        alu_flags_t m;
        m = '0;
        if (op_is_arith(op)) begin
            m.z   = 1'b1;
            m.s   = 1'b1;
            m.cy  = 1'b1;
            m.ov  = 1'b1;
            m.sat = op_is_sat(op);
        end else if (op_is_logic(op)) begin
            m.z  = 1'b1;
            m.s  = 1'b1;
            m.ov = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fa_operand.sv
module fa_operand
    import flag_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHORT_W = 5
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  src_mode_e         mode,
    input  logic              zero_ext,
    output logic [DATA_W-1:0] src
);
    localparam int SHORT_PAD = DATA_W - SHORT_W;
    localparam int LONG_PAD  = DATA_W - IMM_W;

    logic [SHORT_W-1:0] short_f;
    logic               short_fill;
    logic               long_fill;
    logic [DATA_W-1:0]  short_ext;
    logic [DATA_W-1:0]  long_ext;

    assign short_f    = imm_val[SHORT_W-1:0];
    assign short_fill = short_f[SHORT_W-1] & ~zero_ext;
    assign long_fill  = imm_val[IMM_W-1] & ~zero_ext;
    assign short_ext  = {{SHORT_PAD{short_fill}}, short_f};
    assign long_ext   = {{LONG_PAD{long_fill}}, imm_val};

    always_comb begin
        case (mode)
            SRC_SHORT: src = short_ext;
            SRC_LONG:  src = long_ext;
            default:   src = reg_val;
        endcase
    end
endmodule

// File: rtl/fa_arith.sv
module fa_arith
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] oth,
    output logic [DATA_W-1:0] res,
    output logic              f_z,
    output logic              f_s,
    output logic              f_cy,
    output logic              f_ov
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic              sub;
    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic [DATA_W-1:0] rhs_eff;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] raw;

    // One adder serves every form: subtraction is lhs + ~rhs + 1.
    always_comb begin
        sub     = op_is_sub(op);
        lhs     = (op == OP_RSUB) ? src : oth;
        rhs     = (op == OP_RSUB) ? oth : src;
        rhs_eff = sub ? ~rhs : rhs;
        sum     = {1'b0, lhs} + {1'b0, rhs_eff} + {{DATA_W{1'b0}}, sub};
        raw     = sum[MSB:0];
        f_cy    = sub ? ~sum[DATA_W] : sum[DATA_W];
        f_ov    = (lhs[MSB] == rhs_eff[MSB]) && (raw[MSB] != lhs[MSB]);
        f_z     = (raw == '0);
        f_s     = raw[MSB];
        if (op_is_sat(op) && f_ov)
            res = raw[MSB] ? MAX_POS : MIN_NEG;
        else
            res = raw;
    end
endmodule

// File: rtl/fa_logic.sv
module fa_logic
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] oth,
    input  logic              imm_src,
    output logic [DATA_W-1:0] res,
    output logic              f_z,
    output logic              f_s
);
    always_comb begin
        case (op)
            OP_OR:   res = oth | src;
            OP_AND:  res = oth & src;
            OP_XOR:  res = oth ^ src;
            OP_NOT:  res = ~src;
            default: res = '0;
        endcase
        f_z = (res == '0);
        f_s = res[DATA_W-1] & ~((op == OP_AND) && imm_src);
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHORT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [1:0]        imm_mode,
    input  logic              sat_clr,
    output logic [DATA_W-1:0] res_out,
    output logic              res_wr,
    output logic [4:0]        flags_out
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    alu_op_e           op;
    src_mode_e         mode;
    logic              is_logic;
    logic              imm_src;
    logic [DATA_W-1:0] src;

    logic [DATA_W-1:0] a_res;
    logic              a_z, a_s, a_cy, a_ov;
    logic [DATA_W-1:0] l_res;
    logic              l_z, l_s;

    alu_flags_t        flags_q;
    alu_flags_t        flags_new;
    alu_flags_t        upd_mask;
    alu_flags_t        flags_d;
    logic [FLAG_W-1:0] merged;
    logic [DATA_W-1:0] res_q;
    logic              wr_q;
    logic              do_write;

    assign op       = alu_op_e'(op_code);
    assign mode     = src_mode_e'(imm_mode);
    assign is_logic = op_is_logic(op);
    assign imm_src  = (mode == SRC_SHORT) || (mode == SRC_LONG);
    assign do_write = op_valid && op_writes(op);

    fa_operand #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .SHORT_W(SHORT_W)
    ) u_operand (
        .reg_val (opnd_a),
        .imm_val (imm_val),
        .mode    (mode),
        .zero_ext(is_logic),
        .src     (src)
    );

    fa_arith #(.DATA_W(DATA_W)) u_arith (
        .op  (op),
        .src (src),
        .oth (opnd_b),
        .res (a_res),
        .f_z (a_z),
        .f_s (a_s),
        .f_cy(a_cy),
        .f_ov(a_ov)
    );

    fa_logic #(.DATA_W(DATA_W)) u_logic (
        .op     (op),
        .src    (src),
        .oth    (opnd_b),
        .imm_src(imm_src),
        .res    (l_res),
        .f_z    (l_z),
        .f_s    (l_s)
    );

    // Candidate flag values; the mask decides which of them land.
    always_comb begin
        flags_new = '0;
        if (is_logic) begin
            flags_new.z = l_z;
            flags_new.s = l_s;
        end else begin
            flags_new.z   = a_z;
            flags_new.s   = a_s;
            flags_new.cy  = a_cy;
            flags_new.ov  = a_ov;
            flags_new.sat = a_ov;
        end
        upd_mask = op_valid ? flag_update_mask(op) : '0;
        merged   = (flags_q & ~upd_mask) | (flags_new & upd_mask);
        flags_d  = alu_flags_t'(merged);
        // Sticky: a clear drops it, a fresh saturation raises it, set wins.
        flags_d.sat = (flags_q.sat & ~sat_clr) | (upd_mask.sat & a_ov);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            res_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            flags_q <= flags_d;
            wr_q    <= do_write;
            if (do_write)
                res_q <= is_logic ? l_res : a_res;
        end
    end

    assign res_out   = res_q;
    assign res_wr    = wr_q;
    assign flags_out = flags_q;

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CMP) |=> (!res_wr && $stable(res_out)));

    // R7
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_out[4]) |-> $past(sat_clr));

    // R6
    sat_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_is_sat(op) && a_ov) |=>
            ((res_out == MAX_POS || res_out == MIN_NEG) && flags_out[4]));

    // R8
    logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic) |=> (flags_out[2] == $past(flags_out[2]) && !flags_out[3]));

    // R11
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_writes(op) && !op_is_arith(op) && !sat_clr) |=>
            (!res_wr && $stable(flags_out) && $stable(res_out)));

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid) |=> !res_wr);

endmodule

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic [15:0] imm_val;
    logic [1:0]  imm_mode;
    logic        sat_clr;
    logic [31:0] res_out;
    logic        res_wr;
    logic [4:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_res;
    logic        m_wr;
    logic [4:0]  m_flags;

    always #2.5 clk = ~clk;

    flag_alu i_flag_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_val(imm_val),
        .imm_mode(imm_mode), .sat_clr(sat_clr),
        .res_out(res_out), .res_wr(res_wr), .flags_out(flags_out)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1, 4'd2: return "R4";
            4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            4'd8, 4'd9, 4'd10, 4'd11: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Behavioural model of one accepted cycle.
    task automatic model(bit v, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic [15:0] imm, logic [1:0] mode, bit clr);
        bit lg, ar, sop, z, s, cy, ov, nsat;
        logic [31:0] src, l, r, raw;
        longint sv;
        lg = (op >= 4'd8 && op <= 4'd11);
        ar = (op <= 4'd5);
        sop = (op == 4'd4 || op == 4'd5);
        z = m_flags[0]; s = m_flags[1]; cy = m_flags[2]; ov = m_flags[3];
        nsat = m_flags[4] && !clr;
        if (mode == 2'd1) src = lg ? {27'd0, imm[4:0]} : {{27{imm[4]}}, imm[4:0]};
        else if (mode == 2'd2) src = lg ? {16'd0, imm} : {{16{imm[15]}}, imm};
        else src = a;
        m_wr = 1'b0;
        if (v && ar) begin
            if (op == 4'd0 || op == 4'd4) begin
                l = b; r = src;
                raw = l + r;
                cy = (longint'(l) + longint'(r)) > 64'sh0_FFFF_FFFF;
                sv = longint'($signed(l)) + longint'($signed(r));
            end else begin
                if (op == 4'd2) begin l = src; r = b; end
                else begin l = b; r = src; end
                raw = l - r;
                cy = (l < r);
                sv = longint'($signed(l)) - longint'($signed(r));
            end
            ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
            z = (raw == 32'd0);
            s = raw[31];
            if (sop && ov) begin
                raw = (sv > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
                nsat = 1'b1;
            end
            if (op != 4'd3) begin m_res = raw; m_wr = 1'b1; end
        end else if (v && lg) begin
            case (op)
                4'd8:    raw = b | src;
                4'd9:    raw = b & src;
                4'd10:   raw = b ^ src;
                default: raw = ~src;
            endcase
            z = (raw == 32'd0);
            s = raw[31] && !(op == 4'd9 && (mode == 2'd1 || mode == 2'd2));
            ov = 1'b0;
            m_res = raw; m_wr = 1'b1;
        end
        m_flags = {nsat, ov, cy, s, z};
    endtask

    task automatic run(string tag, bit v, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] imm, logic [1:0] mode, bit clr);
        op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
        imm_val = imm; imm_mode = mode; sat_clr = clr;
        model(v, op, a, b, imm, mode, clr);
        @(negedge clk);
        chk(tag, "res_out", res_out, m_res);
        chk(tag, "res_wr", {31'd0, res_wr}, {31'd0, m_wr});
        chk(tag, "flags", {27'd0, flags_out}, {27'd0, m_flags});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0;
            3: return 32'hFFFF_FFFF;
            4: return 32'($urandom_range(0, 9));
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
        imm_val = 0; imm_mode = 0; sat_clr = 0;
        m_res = 0; m_wr = 0; m_flags = 0;
        // R1: drive junk during reset, outputs must read zero
        @(negedge clk);
        op_valid = 1; op_code = 4'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
        repeat (2) @(negedge clk);
        chk("R1", "res_out", res_out, 32'd0);
        chk("R1", "res_wr", {31'd0, res_wr}, 32'd0);
        chk("R1", "flags", {27'd0, flags_out}, 32'd0);
        rst = 0; op_valid = 0;
        @(negedge clk);

        // R3 carry and overflow
        run("R3", 1, 4'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        run("R3", 1, 4'd0, 32'h1, 32'h7FFF_FFFF, 0, 0, 0);
        run("R3", 1, 4'd0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        // R4 borrow, reverse, overflow
        run("R4", 1, 4'd1, 32'd7, 32'd5, 0, 0, 0);
        run("R4", 1, 4'd2, 32'd10, 32'd3, 0, 0, 0);
        run("R4", 1, 4'd1, 32'd1, 32'h8000_0000, 0, 0, 0);
        // R2 idle: no strobe, result held
        run("R2", 0, 4'd0, 32'd9, 32'd9, 0, 0, 0);
        run("R2", 0, 4'd8, 32'd9, 32'd9, 0, 0, 0);
        // R5 compare equal and borrowing
        run("R5", 1, 4'd3, 32'h1234, 32'h1234, 0, 0, 0);
        run("R5", 1, 4'd3, 32'd2, 32'd1, 0, 0, 0);
        // R6 clamps both ways
        run("R6", 1, 4'd4, 32'h1, 32'h7FFF_FFFF, 0, 0, 0);
        run("R6", 1, 4'd5, 32'h1, 32'h8000_0000, 0, 0, 0);
        run("R6", 1, 4'd4, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0);
        // R7 sticky, clear, set-wins
        run("R7", 1, 4'd0, 32'd1, 32'd1, 0, 0, 0);
        run("R7", 1, 4'd4, 32'd1, 32'd1, 0, 0, 0);
        run("R7", 0, 4'd0, 0, 0, 0, 0, 1);
        run("R7", 1, 4'd5, 32'h1, 32'h8000_0000, 0, 0, 1);
        run("R7", 1, 4'd1, 32'h1, 32'h8000_0000, 0, 0, 1);
        // R8 carry kept through logic ops
        run("R8", 1, 4'd0, 32'hFFFF_FFFF, 32'h2, 0, 0, 0);
        run("R8", 1, 4'd8, 32'h8000_0000, 32'h1, 0, 0, 0);
        run("R8", 1, 4'd11, 32'h0, 32'h5, 0, 0, 0);
        run("R8", 1, 4'd10, 32'hA5A5, 32'hA5A5, 0, 0, 0);
        // R9 AND with immediate keeps S low
        run("R9", 1, 4'd9, 32'h0, 32'hFFFF_FFFF, 16'hFFFF, 2'd2, 0);
        run("R9", 1, 4'd9, 32'h0, 32'hFFFF_FFFF, 16'h001F, 2'd1, 0);
        // R10 immediate widening
        run("R10", 1, 4'd0, 32'h0, 32'd0, 16'h001F, 2'd1, 0);
        run("R10", 1, 4'd0, 32'h0, 32'd0, 16'h8000, 2'd2, 0);
        run("R10", 1, 4'd8, 32'h0, 32'd0, 16'h8000, 2'd2, 0);
        run("R10", 1, 4'd8, 32'h0, 32'd0, 16'h0010, 2'd1, 0);
        run("R10", 1, 4'd0, 32'h40, 32'd1, 16'h0003, 2'd3, 0);
        // R11 unassigned codes
        run("R11", 1, 4'd7, 32'h1, 32'h1, 0, 0, 0);
        run("R11", 1, 4'd15, 32'hFFFF_FFFF, 32'h0, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            run(tag_of(op), ($urandom_range(0, 7) != 0), op, pick(), pick(),
                16'($urandom), 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule